// File: doc/BRIEF.md
# Comparator Output Conditioning and Wake Logic

This block sits behind one or more analog comparators and turns each raw, asynchronous comparator bit into signals that digital logic can consume safely. For every channel it offers three routed output styles: the raw bit passed straight through, a level retimed into the system clock domain, or a short pulse fired on a chosen edge of that retimed level. A readable compare value always shows the retimed level.

The same edge detector feeds a sticky interrupt flag per channel. When the flag is set, its per-channel mask is set and the channel's edge selection is not switched off, the channel asks for an interrupt. The OR of all such requests forms a single wake request for the power controller. Software clears a flag by pulsing that channel's clear input high for one cycle.

Channels are fully independent, and the number of channels, synchronizer depth and pulse width are parameters. The default is two channels, two synchronizer flops and a two-cycle pulse.

Top module: `cmp_out_cond`

## Requirements
- R1: `cmp_val[i]` shows `raw_in[i]` after a synchronizer of two flops. A change of the raw input that is applied between clock edges appears on `cmp_val[i]` after the second rising edge that follows.
- R2: When `bypass[i]` is 1, `route_out[i]` equals `raw_in[i]` with no clocked delay, whatever the other controls are.
- R3: When `bypass[i]` is 0 and `level_sel[i]` is 1, `route_out[i]` equals `cmp_val[i]`.
- R4: When `bypass[i]` is 0 and `level_sel[i]` is 0, `route_out[i]` is a pulse exactly 2 clock cycles wide. It rises one clock edge after `cmp_val[i]` shows a selected edge. A further selected edge during a pulse restarts the 2-cycle count.
- R5: Each channel has a 2-bit field `edge_type[2*i+1:2*i]`. The encodings are 00 = off, 01 = rising, 10 = falling and 11 = both edges. Only edges of the selected kind fire a pulse or set the flag.
- R6: `irq_status[i]` becomes 1 one clock edge after `cmp_val[i]` shows a selected edge. It then stays 1 until a cycle with `irq_clr[i]` = 1 and no new selected edge, which clears it. When a new edge and a clear fall in the same cycle, the edge wins.
- R7: With `edge_type` = 00, edges of the comparator set no flag and fire no pulse.
- R8: `irq_masked[i]` is 1 exactly when `irq_status[i]` is 1, `irq_mask[i]` is 1 and `edge_type` for that channel is not 00. `wake_req` is the OR of all `irq_masked` bits.
- R9: Activity or controls on one channel never change the outputs of another channel.
- R10: After a synchronous reset, held high for at least one rising edge, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | NCH | Raw asynchronous comparator bits |
| bypass | input | NCH | 1 routes the raw bit directly |
| level_sel | input | NCH | 1 selects retimed level, 0 selects pulse |
| edge_type | input | 2*NCH | Per-channel edge select (00 off, 01 rise, 10 fall, 11 both) |
| irq_mask | input | NCH | Per-channel interrupt enable |
| irq_clr | input | NCH | Write-one clear of the sticky flag |
| route_out | output | NCH | Routed output per channel |
| irq_status | output | NCH | Sticky raw interrupt flags |
| irq_masked | output | NCH | Flags gated by mask and edge selection |
| wake_req | output | 1 | OR of all masked requests |
| cmp_val | output | NCH | Retimed comparator level |

## Verification
The bench checks the pulse width directly. A design that counts one cycle too many or too few shows up as a 1- or 3-cycle pulse, or as a pulse that starts one edge early or late. It also checks that a falling edge leaves a rising-only channel quiet, and that the off setting blocks both the flag and the pulse. A design that forgets to gate on the off encoding would raise a wake from a stale flag. Random toggles with clears landing on edges test that the edge wins over the clear, and that a pulse retriggers correctly. A design with the wrong priority would lose an interrupt. A check that one channel toggles while the other's outputs stay put catches crossed channel indices.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned DEF_NCH     = 2;
  localparam int unsigned DEF_STAGES  = 2;
  localparam int unsigned DEF_PULSE_W = 2;
endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cmpc_edge.sv
module cmpc_edge
  import cmpc_pkg::*;
#(
  parameter int unsigned PULSE_W = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_sel_e sel,
  output logic      hit,
  output logic      pulse
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic          prev;
  logic [CW-1:0] cnt;
  logic          rise, fall;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= lvl;
      if (hit)           cnt <= LOAD;
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/cmpc_flag.sv
module cmpc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  input  logic armed,
  output logic status,
  output logic masked
);
  always_ff @(posedge clk) begin
    if (rst)      status <= 1'b0;
    else if (set) status <= 1'b1;
    else if (clr) status <= 1'b0;
  end

  assign masked = status & mask & armed;
endmodule

// File: rtl/cmpc_chan.sv
module cmpc_chan
  import cmpc_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned PULSE_W = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      raw,
  input  logic      bypass,
  input  logic      level_sel,
  input  edge_sel_e sel,
  input  logic      mask,
  input  logic      clr,
  output logic      route,
  output logic      status,
  output logic      masked,
  output logic      lvl
);
  logic hit, pulse;

  cmpc_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(lvl)
  );

  cmpc_edge #(.PULSE_W(PULSE_W)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .sel(sel), .hit(hit), .pulse(pulse)
  );

  cmpc_flag u_flag (
    .clk(clk), .rst(rst), .set(hit), .clr(clr), .mask(mask),
    .armed(sel != EDGE_OFF), .status(status), .masked(masked)
  );

  always_comb begin
    if (bypass)         route = raw;
    else if (level_sel) route = lvl;
    else                route = pulse;
  end
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmpc_pkg::*;
#(
  parameter int unsigned NCH     = DEF_NCH,
  parameter int unsigned STAGES  = DEF_STAGES,
  parameter int unsigned PULSE_W = DEF_PULSE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   raw_in,
  input  logic [NCH-1:0]   bypass,
  input  logic [NCH-1:0]   level_sel,
  input  logic [2*NCH-1:0] edge_type,
  input  logic [NCH-1:0]   irq_mask,
  input  logic [NCH-1:0]   irq_clr,
  output logic [NCH-1:0]   route_out,
  output logic [NCH-1:0]   irq_status,
  output logic [NCH-1:0]   irq_masked,
  output logic             wake_req,
  output logic [NCH-1:0]   cmp_val
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmpc_chan #(.STAGES(STAGES), .PULSE_W(PULSE_W)) u_chan (
      .clk(clk), .rst(rst), .raw(raw_in[g]), .bypass(bypass[g]),
      .level_sel(level_sel[g]), .sel(edge_sel_e'(edge_type[2*g +: 2])),
      .mask(irq_mask[g]), .clr(irq_clr[g]), .route(route_out[g]),
      .status(irq_status[g]), .masked(irq_masked[g]), .lvl(cmp_val[g])
    );
  end

  assign wake_req = |irq_masked;
endmodule

// File: rtl/cmpc_chk.sv
module cmpc_chk #(
  parameter int unsigned NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   bypass,
  input logic [NCH-1:0]   level_sel,
  input logic [2*NCH-1:0] edge_type,
  input logic [NCH-1:0]   irq_mask,
  input logic [NCH-1:0]   irq_clr,
  input logic [NCH-1:0]   route_out,
  input logic [NCH-1:0]   irq_status,
  input logic [NCH-1:0]   irq_masked,
  input logic             wake_req
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (irq_status[i] && !irq_clr[i]) |=> irq_status[i]); // R6

    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (!irq_status[i] && edge_type[2*i +: 2] == 2'b00) |=> !irq_status[i]); // R7

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
      irq_masked[i] |-> (irq_status[i] && irq_mask[i] && edge_type[2*i +: 2] != 2'b00)); // R8

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
      ($rose(route_out[i]) && !bypass[i] && !level_sel[i] && !$past(bypass[i]) && !$past(level_sel[i]))
      |=> (route_out[i] || bypass[i] || level_sel[i])); // R4
  end

  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (irq_masked != '0)); // R8
endmodule

bind cmp_out_cond cmpc_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bypass(bypass), .level_sel(level_sel),
  .edge_type(edge_type), .irq_mask(irq_mask), .irq_clr(irq_clr),
  .route_out(route_out), .irq_status(irq_status), .irq_masked(irq_masked),
  .wake_req(wake_req)
);

// File: tb/test_cmp_out_cond.sv
`timescale 1ns/1ps
module test_cmp_out_cond;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   raw_in = '0, bypass = '0, level_sel = '0, irq_mask = '0, irq_clr = '0;
  logic [2*NCH-1:0] edge_type = '0;
  logic [NCH-1:0]   route_out, irq_status, irq_masked, cmp_val;
  logic             wake_req;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cmp_out_cond #(.NCH(NCH)) i_cmp_out_cond (
    .clk(clk), .rst(rst), .raw_in(raw_in), .bypass(bypass), .level_sel(level_sel),
    .edge_type(edge_type), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .route_out(route_out), .irq_status(irq_status), .irq_masked(irq_masked),
    .wake_req(wake_req), .cmp_val(cmp_val)
  );

  // reference model built from the requirements
  logic [NCH-1:0] m_s1, m_s2, m_prev, m_st;
  int             m_cnt [NCH];

  function automatic logic sel_edge(logic [1:0] t, logic cur, logic prv);
    case (t)
      2'b01:   return cur & ~prv;
      2'b10:   return ~cur & prv;
      2'b11:   return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0;
      for (int i = 0; i < NCH; i++) m_cnt[i] <= 0;
    end else begin
      m_s1 <= raw_in; m_s2 <= m_s1; m_prev <= m_s2;
      for (int i = 0; i < NCH; i++) begin
        if (sel_edge(edge_type[2*i +: 2], m_s2[i], m_prev[i])) begin
          m_cnt[i] <= 2; m_st[i] <= 1'b1;
        end else begin
          if (m_cnt[i] > 0) m_cnt[i] <= m_cnt[i] - 1;
          if (irq_clr[i]) m_st[i] <= 1'b0;
        end
      end
    end
  end

  function automatic logic exp_route(int i);
    if (bypass[i]) return raw_in[i];
    if (level_sel[i]) return m_s2[i];
    return m_cnt[i] > 0;
  endfunction

  function automatic logic exp_masked(int i);
    return m_st[i] & irq_mask[i] & (edge_type[2*i +: 2] != 2'b00);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model();
    logic [NCH-1:0] em;
    em = '0;
    for (int i = 0; i < NCH; i++) begin
      check(bypass[i] ? "R2 route" : (level_sel[i] ? "R3 route" : "R4 route"),
            32'(route_out[i]), 32'(exp_route(i)));
      em[i] = exp_masked(i);
    end
    check("R1 cmp_val", 32'(cmp_val), 32'(m_s2));
    check("R6 irq_status", 32'(irq_status), 32'(m_st));
    check("R8 irq_masked", 32'(irq_masked), 32'(em));
    check("R8 wake_req", 32'(wake_req), 32'(|em));
  endtask

  task automatic settle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int hi_cnt, first_hi;
    void'($urandom(32'h5eed_c0de));
    settle(3);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 route_out", 32'(route_out), 0);
    check("R10 irq_status", 32'(irq_status), 0);
    check("R10 cmp_val", 32'(cmp_val), 0);
    check("R10 wake_req", 32'(wake_req), 0);

    // R4 pulse width, channel 0 rising
    edge_type = 4'b0001; irq_mask = 2'b01;
    raw_in[0] = 1'b1;
    hi_cnt = 0; first_hi = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 2) check("R1 cmp_val after 2 edges", 32'(cmp_val[0]), 1);
      if (route_out[0]) begin
        hi_cnt++;
        if (first_hi == 0) first_hi = k;
      end
    end
    check("R4 pulse width", 32'(hi_cnt), 2);
    check("R4 pulse start", 32'(first_hi), 3);
    check("R6 flag set", 32'(irq_status[0]), 1);
    check("R8 wake", 32'(wake_req), 1);
    // R9 channel 1 untouched
    check("R9 ch1 status", 32'(irq_status[1]), 0);
    check("R9 ch1 cmp_val", 32'(cmp_val[1]), 0);
    check("R9 ch1 route", 32'(route_out[1]), 0);

    // R6 clear
    irq_clr = 2'b01; @(negedge clk); irq_clr = '0;
    check("R6 flag cleared", 32'(irq_status[0]), 0);

    // R5 falling edge ignored by rising-only channel
    raw_in[0] = 1'b0; hi_cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (route_out[0]) hi_cnt++;
    end
    check("R5 fall ignored, flag", 32'(irq_status[0]), 0);
    check("R5 fall ignored, pulse", 32'(hi_cnt), 0);

    // R7 off blocks flag and pulse
    edge_type = 4'b0000;
    raw_in[0] = 1'b1; hi_cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (route_out[0]) hi_cnt++;
    end
    check("R7 off no flag", 32'(irq_status[0]), 0);
    check("R7 off no pulse", 32'(hi_cnt), 0);
    check("R7 off no wake", 32'(wake_req), 0);

    // R2 bypass follows raw between edges
    bypass[1] = 1'b1; raw_in[1] = 1'b1; #1;
    check("R2 bypass immediate", 32'(route_out[1]), 1);
    raw_in[1] = 1'b0; #1;
    check("R2 bypass immediate low", 32'(route_out[1]), 0);
    settle(4);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      check_model();
      irq_clr = '0;
      for (int i = 0; i < NCH; i++) begin
        if ($urandom_range(0, 4) == 0) raw_in[i] = ~raw_in[i];
        if ($urandom_range(0, 9) == 0) irq_clr[i] = 1'b1;
      end
      if ($urandom_range(0, 39) == 0) begin
        bypass    = NCH'($urandom_range(0, 3)) & NCH'($urandom_range(0, 3));
        level_sel = NCH'($urandom_range(0, 3));
        edge_type = 4'($urandom_range(0, 15));
        irq_mask  = NCH'($urandom_range(0, 3));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule